// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver with Ready Handshake

This block is one channel of a clock-synchronous serial port, used as a receiver. It collects 8-bit frames, least significant bit first, sampling the data line on each rising edge of the serial clock. The serial clock is either produced inside the block from the system clock by a fixed divider or taken from an external master. A finished byte goes to a receive buffer. The block then sets a completion flag and can raise a one-cycle interrupt request. If a frame finishes while the previous byte is still unread, an overrun flag is set.

Reception is tied to the transmit side. A frame is accepted only after the CPU has written the transmit buffer, even with dummy data, which arms the channel for one frame. In external-clock mode with the handshake enabled, the ready output goes high when the channel is armed and drops low when the CPU reads the receive buffer. For back-to-back reception, software therefore writes the transmit buffer before reading the receive buffer.

Register map on `cpu_addr`: 0 = transmit buffer (read/write, a write arms reception), 1 = receive buffer (read; the read clears the completion flag), 2 = control/status. Control/status bits: 0 external clock select, 1 handshake enable, 2 receiver enable, 3 interrupt source select (0 = receive), 4 completion flag (read only), 5 overrun flag (read only), 6 overrun clear (write 1, reads 0), 7 reads 0.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset, `rts_o` and `rx_irq` are 0, `ser_clk_out` is 1, and the receive buffer and control/status (address 2) read 0x00.
- R2: In external-clock mode an armed channel shifts in 8 bits, LSB first, sampled on rising edges of `ser_clk_in`; the byte then reads back at address 1 and bit 4 of address 2 reads 1.
- R3: In internal-clock mode an armed channel drives exactly 8 low pulses on `ser_clk_out` (each half period CLK_DIV system clocks), samples on each rising edge, and `ser_clk_out` stays high when idle.
- R4: Serial clock edges while the channel is not armed (no transmit buffer write since the last frame) leave the completion flag, the interrupt and the receive buffer unchanged.
- R5: When the completion flag rises and control bit 3 is 0, `rx_irq` is high for exactly one cycle; with bit 3 at 1, completion raises no interrupt.
- R6: A frame that finishes while the completion flag is 1 sets the overrun flag (bit 5) and the receive buffer keeps the older byte.
- R7: Reading address 1 clears the completion flag.
- R8: A transmit buffer write with external clock, handshake and receiver enabled drives `rts_o` high; a read of address 1 drives it low; in internal-clock mode it stays low.
- R9: The overrun flag clears when control is written with bit 6 at 1, or with the receiver enable bit 2 at 0.
- R10: Control/status reads back the written mode bits 0 to 3 together with the flags at bits 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_in | input | 1 | Serial clock from an external master |
| ser_data_in | input | 1 | Serial data line |
| ser_clk_out | output | 1 | Generated serial clock, idle high |
| rts_o | output | 1 | Ready-to-receive handshake |
| rx_irq | output | 1 | Receive interrupt request, one-cycle pulse |
| cpu_sel | input | 1 | Register access select |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe (side effects at the clock edge) |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from the registers |

## Verification
An external rising edge goes through two synchroniser flops and an edge detector, so the eighth edge updates the buffer and flag on the third system clock after it. The bench waits six clocks after that edge before it reads, and holds each external half period for eight clocks so that data is settled well before every sampled edge. The handshake output and the completion flag change on the clock edge that ends a register access. The bench samples them at the next falling edge. Interrupt pulses are counted by a monitor on every clock, together with any pulse longer than one cycle, so the checks do not depend on the exact cycle in which a frame ends.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    localparam int BYTE_W = 8;

    localparam logic [1:0] ADDR_TXB = 2'd0;
    localparam logic [1:0] ADDR_RXB = 2'd1;
    localparam logic [1:0] ADDR_CTL = 2'd2;

    localparam int BIT_EXT  = 0;
    localparam int BIT_RTSE = 1;
    localparam int BIT_RXEN = 2;
    localparam int BIT_ISEL = 3;
    localparam int BIT_OCLR = 6;

    typedef struct packed {
        logic [BYTE_W-1:0] txbuf;
        logic [BYTE_W-1:0] rxbuf;
        logic              ext_sel;
        logic              rts_en;
        logic              rx_en;
        logic              irq_sel;
        logic              done;
        logic              ovr;
        logic              armed;
        logic              rts;
        logic              irq;
    } ssr_regs_t;
endpackage

// File: rtl/ssr_clk_unit.sv
module ssr_clk_unit #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic run_int,
    input  logic ser_clk_in,
    input  logic ser_data_in,
    output logic sclk_out,
    output logic sample_tick,
    output logic data_sync
);
    localparam int DIV_W = $clog2(CLK_DIV + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
        logic [2:0]       csync;
        logic [1:0]       dsync;
    } clk_regs_t;

    clk_regs_t q, d;
    logic      int_rise;
    logic      ext_rise;

    always_comb begin
        d        = q;
        int_rise = 1'b0;
        d.csync  = {q.csync[1:0], ser_clk_in};
        d.dsync  = {q.dsync[0], ser_data_in};
        if (!run_int) begin
            d.cnt  = '0;
            d.sclk = 1'b1;
        end else if (q.cnt == DIV_LAST) begin
            d.cnt    = '0;
            d.sclk   = ~q.sclk;
            int_rise = ~q.sclk;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
        ext_rise = q.csync[1] & ~q.csync[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt   <= '0;
            q.sclk  <= 1'b1;
            q.csync <= '0;
            q.dsync <= '0;
        end else begin
            q <= d;
        end
    end

    assign sclk_out    = q.sclk;
    assign sample_tick = ext_sel ? ext_rise : int_rise;
    assign data_sync   = q.dsync[1];
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              tick,
    input  logic              bit_in,
    output logic              frame_done,
    output logic [DATA_W-1:0] frame_byte
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
    } sh_regs_t;

    sh_regs_t q, d;

    always_comb begin
        d          = q;
        frame_done = 1'b0;
        frame_byte = {bit_in, q.sh[DATA_W-1:1]};
        if (clear) begin
            d.cnt = '0;
        end else if (tick) begin
            d.sh = frame_byte;
            if (q.cnt == CNT_LAST) begin
                d.cnt      = '0;
                frame_done = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
    import ssr_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_in,
    input  logic              ser_data_in,
    output logic              ser_clk_out,
    output logic              rts_o,
    output logic              rx_irq,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [1:0]        cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata
);
    ssr_regs_t q, d;

    logic              tick;
    logic              gated_tick;
    logic              data_s;
    logic              frame_done;
    logic [BYTE_W-1:0] frame_byte;
    logic              wr_en;
    logic              rd_en;
    logic              done_kept;

    ssr_clk_unit #(.CLK_DIV(CLK_DIV)) i_clk_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_sel     (q.ext_sel),
        .run_int     (q.armed & ~q.ext_sel),
        .ser_clk_in  (ser_clk_in),
        .ser_data_in (ser_data_in),
        .sclk_out    (ser_clk_out),
        .sample_tick (tick),
        .data_sync   (data_s)
    );

    assign gated_tick = tick & q.armed & q.rx_en;

    ssr_shifter #(.DATA_W(BYTE_W)) i_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (~q.rx_en),
        .tick       (gated_tick),
        .bit_in     (data_s),
        .frame_done (frame_done),
        .frame_byte (frame_byte)
    );

    always_comb begin
        d         = q;
        d.irq     = 1'b0;
        wr_en     = cpu_sel & cpu_wr;
        rd_en     = cpu_sel & cpu_rd;
        done_kept = q.done;

        if (rd_en && cpu_addr == ADDR_RXB) begin
            d.done    = 1'b0;
            d.rts     = 1'b0;
            done_kept = 1'b0;
        end

        if (frame_done) begin
            d.armed = 1'b0;
            if (done_kept) begin
                d.ovr = 1'b1;
            end else begin
                d.rxbuf = frame_byte;
                d.done  = 1'b1;
                d.irq   = ~q.irq_sel;
            end
        end

        if (wr_en && cpu_addr == ADDR_TXB) begin
            d.txbuf = cpu_wdata;
            if (q.rx_en) begin
                d.armed = 1'b1;
                if (q.ext_sel && q.rts_en) d.rts = 1'b1;
            end
        end

        if (wr_en && cpu_addr == ADDR_CTL) begin
            d.ext_sel = cpu_wdata[BIT_EXT];
            d.rts_en  = cpu_wdata[BIT_RTSE];
            d.rx_en   = cpu_wdata[BIT_RXEN];
            d.irq_sel = cpu_wdata[BIT_ISEL];
            if (cpu_wdata[BIT_OCLR]) d.ovr = 1'b0;
            if (!cpu_wdata[BIT_RTSE]) d.rts = 1'b0;
            if (!cpu_wdata[BIT_RXEN]) begin
                d.armed = 1'b0;
                d.ovr   = 1'b0;
                d.rts   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (cpu_addr)
            ADDR_TXB: cpu_rdata = q.txbuf;
            ADDR_RXB: cpu_rdata = q.rxbuf;
            ADDR_CTL: cpu_rdata = {2'b00, q.ovr, q.done, q.irq_sel,
                                   q.rx_en, q.rts_en, q.ext_sel};
            default:  cpu_rdata = '0;
        endcase
    end

    assign rts_o  = q.rts;
    assign rx_irq = q.irq;
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker
    import ssr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rx_irq,
    input logic              rts_o,
    input logic              cpu_sel,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [1:0]        cpu_addr,
    input logic              done_flag,
    input logic              ovr_flag,
    input logic [BYTE_W-1:0] rx_buffer,
    input logic              frame_end
);
    logic rxb_read;
    assign rxb_read = cpu_sel & cpu_rd & ~cpu_wr & (cpu_addr == ADDR_RXB);

    // R5
    a_r5_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    // R5
    a_r5_irq_on_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (done_flag && !$past(done_flag)));

    // R8
    a_r8_rts_low_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rxb_read |=> !rts_o);

    // R6
    a_r6_overrun_keeps_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $stable(rx_buffer));

    // R2
    a_r2_done_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(frame_end));

    // R7
    a_r7_read_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        (rxb_read && !frame_end) |=> !done_flag);
endmodule

bind sync_serial_rx ssr_checker i_ssr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_irq    (rx_irq),
    .rts_o     (rts_o),
    .cpu_sel   (cpu_sel),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_addr  (cpu_addr),
    .done_flag (q.done),
    .ovr_flag  (q.ovr),
    .rx_buffer (q.rxbuf),
    .frame_end (frame_done)
);

// File: tb/test_sync_serial_rx.sv
`timescale 1ns/1ps
module test_sync_serial_rx;
    localparam int CLK_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b1;
    logic       ext_bit = 1'b0;
    logic       use_ext = 1'b1;
    logic       slave_bit = 1'b0;
    logic [7:0] slave_byte = 8'h00;
    logic [2:0] slave_idx = 3'd0;
    logic       ser_data;
    logic       ser_clk_out, rts_o, rx_irq;
    logic       cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;

    int tests = 0;
    int fails = 0;
    int irq_cnt = 0;
    int irq_long = 0;
    int int_rises = 0;
    int cycles = 0;
    logic last_irq = 1'b0;

    always #2.5 clk = ~clk;

    assign ser_data = use_ext ? ext_bit : slave_bit;

    sync_serial_rx #(.CLK_DIV(CLK_DIV)) i_sync_serial_rx (
        .clk(clk), .rst_n(rst_n), .ser_clk_in(ext_clk), .ser_data_in(ser_data),
        .ser_clk_out(ser_clk_out), .rts_o(rts_o), .rx_irq(rx_irq),
        .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
    );

    // slave model for the generated clock: next bit on each falling edge
    always @(negedge ser_clk_out) begin
        slave_bit = slave_byte[slave_idx];
        slave_idx = slave_idx + 3'd1;
    end

    always @(posedge ser_clk_out) int_rises++;

    always @(posedge clk) begin
        if (rst_n && rx_irq) begin
            irq_cnt++;
            if (last_irq) irq_long++;
        end
        last_irq = rx_irq;
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            summary();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = v;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_rd = 1'b1; cpu_addr = a;
        #1 v = cpu_rdata;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_rd = 1'b0;
    endtask

    task automatic send_ext(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ext_clk = 1'b0; ext_bit = b[i];
            repeat (8) @(negedge clk);
            ext_clk = 1'b1;
            repeat (8) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    // {external clock, byte}
    localparam logic [8:0] VEC [0:5] = '{9'h1A5, 9'h03C, 9'h100, 9'h0FF, 9'h181, 9'h05A};

    logic [7:0] rv;
    int irq0, rise0;

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rts after reset", {31'd0, rts_o}, 0);
        chk("R1 irq after reset", {31'd0, rx_irq}, 0);
        chk("R1 sclk idle after reset", {31'd0, ser_clk_out}, 1);
        rst_n = 1'b1;
        cpu_read(2'd2, rv); chk("R1 control after reset", rv, 8'h00);
        cpu_read(2'd1, rv); chk("R1 rx buffer after reset", rv, 8'h00);

        foreach (VEC[k]) begin
            use_ext = VEC[k][8];
            cpu_write(2'd2, VEC[k][8] ? 8'h07 : 8'h06);
            cpu_read(2'd2, rv); chk("R10 mode bits readback", rv, VEC[k][8] ? 8'h07 : 8'h06);
            irq0 = irq_cnt; rise0 = int_rises;
            slave_byte = VEC[k][7:0];
            cpu_write(2'd0, 8'h00);
            chk("R8 rts on arm", {31'd0, rts_o}, {31'd0, VEC[k][8]});
            if (VEC[k][8]) send_ext(VEC[k][7:0]);
            else repeat (100) @(negedge clk);
            if (!VEC[k][8]) begin
                chk("R3 generated pulses", int_rises - rise0, 8);
                chk("R3 sclk idle high", {31'd0, ser_clk_out}, 1);
            end
            cpu_read(2'd2, rv); chk("R2 done flag", {31'd0, rv[4]}, 1);
            chk("R5 one interrupt", irq_cnt - irq0, 1);
            cpu_read(2'd1, rv); chk(VEC[k][8] ? "R2 byte" : "R3 byte", rv, VEC[k][7:0]);
            chk("R8 rts low after read", {31'd0, rts_o}, 0);
            cpu_read(2'd2, rv); chk("R7 done cleared", {31'd0, rv[4]}, 0);
        end

        // R4: clock edges without arming
        use_ext = 1'b1;
        cpu_write(2'd2, 8'h07);
        irq0 = irq_cnt;
        send_ext(8'h33);
        cpu_read(2'd2, rv); chk("R4 no done when unarmed", {31'd0, rv[4]}, 0);
        chk("R4 no irq when unarmed", irq_cnt - irq0, 0);
        cpu_read(2'd1, rv); chk("R4 buffer unchanged", rv, 8'h5A);

        // R5: interrupt source select = 1
        cpu_write(2'd2, 8'h0F);
        irq0 = irq_cnt;
        cpu_write(2'd0, 8'h00);
        send_ext(8'hC3);
        cpu_read(2'd2, rv); chk("R5 done without irq", rv, 8'h1F);
        chk("R5 no irq when select=1", irq_cnt - irq0, 0);
        cpu_read(2'd1, rv); chk("R5 byte", rv, 8'hC3);

        // R6: overrun with back-to-back arming
        cpu_write(2'd2, 8'h07);
        cpu_write(2'd0, 8'h00);
        send_ext(8'h11);
        cpu_write(2'd0, 8'h00);
        chk("R8 rts high on second arm", {31'd0, rts_o}, 1);
        send_ext(8'h22);
        cpu_read(2'd2, rv); chk("R6 overrun flag", rv, 8'h37);
        cpu_read(2'd1, rv); chk("R6 older byte kept", rv, 8'h11);

        // R9: clear bit
        cpu_write(2'd2, 8'h47);
        cpu_read(2'd2, rv); chk("R9 clear bit", rv, 8'h07);

        // R9: receiver disable
        cpu_write(2'd0, 8'h00);
        send_ext(8'h44);
        cpu_write(2'd0, 8'h00);
        send_ext(8'h55);
        cpu_read(2'd2, rv); chk("R6 second overrun", rv, 8'h37);
        cpu_write(2'd2, 8'h03);
        cpu_read(2'd2, rv); chk("R9 disable clears overrun", rv, 8'h13);
        cpu_read(2'd1, rv); chk("R6 byte after disable", rv, 8'h44);

        chk("R5 no long pulse", irq_long, 0);
        summary();
    end
endmodule